// File: doc/BRIEF.md
# Automatic power-save and deep power-down supervisor

This block sits beside the command and array logic of a memory interface. It watches the address bus and the three active-low controls (chip enable, output enable, write enable) and decides which low-power state the device is in. A quiet-time counter moves an armed, idle device into power-save. While in power-save, a register keeps the most recently read word on the data outputs. Any new address or control edge brings the device back to active.

Chip enable high puts the device in standby and turns the output drivers off. A running program or erase keeps the device active until it completes. Holding the deep power-down input low has several effects: the write machine is held in reset, status is cleared, a running operation is aborted and marked invalid, and arming is cancelled. When the input returns high, a fixed recovery window must pass before any command is accepted.

All inputs are sampled on the rising clock edge. Timing is counted in clock cycles: `IDLE_CYCLES` sets the quiet time and `RECOV_CYCLES` sets the recovery window.

Top module: `lps_supervisor`

## Requirements
- R1: With chip enable low, no operation busy and arming done, `mode` becomes power-save (2) on the (IDLE_CYCLES+1)-th clock edge after the edge that first sampled the last change on `addr`, `ce_n`, `oe_n` or `we_n`. Any change sampled earlier restarts the count.
- R2: Power-save is never entered until a change of `ce_n` has been sampled after reset or after the last deep power-down. Before that, an idle device with chip enable low stays in active (1).
- R3: While in power-save, `dq_out` keeps the last latched read word even if `rd_data` changes. A sampled change on any watched input returns `mode` to active (1) on that same edge, and a read in progress latches the new `rd_data` on that edge.
- R4: On every edge where `ce_n`=0, `oe_n`=0, `we_n`=1 and the next mode is active, `dq_out` takes `rd_data`. `dq_oe` is 1 exactly when `ce_n`=0, `oe_n`=0, `we_n`=1 and `mode` is active or power-save.
- R5: With `ce_n`=1 and no operation busy, `mode` becomes standby (0) on the next edge, and `dq_oe` is 0.
- R6: With `ce_n`=1 while `op_busy`=1, `mode` stays active (1). After `op_done`, it becomes standby one edge after `op_busy` falls.
- R7: An edge that samples `pd_n`=0 sets `mode` to deep power-down (3), `wsm_clear` to 1 and `op_busy` to 0, and cancels arming.
- R8: Sampling `pd_n`=0 while `op_busy`=1 sets `result_invalid` to 1. It stays 1 through recovery and clears only when `op_done` ends a newly accepted operation.
- R9: When `pd_n` returns high, `mode` is recovery (4) for exactly RECOV_CYCLES cycles and then becomes active or standby. `cmd_accept` is 0 throughout deep power-down and recovery.
- R10: `cmd_accept` is 1 exactly when `ce_n`=0 and `we_n`=0 and `mode` is neither 3 nor 4. `op_start` sets `op_busy` only when `cmd_accept` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| pd_n | input | 1 | Deep power-down / reset request, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | AW | Address bus |
| rd_data | input | DW | Array read word |
| op_start | input | 1 | A program or erase begins |
| op_done | input | 1 | The running operation finished |
| dq_out | output | DW | Held output data |
| dq_oe | output | 1 | Output driver enable (0 = high impedance) |
| cmd_accept | output | 1 | A command write may be recognised this cycle |
| mode | output | 3 | 0 standby, 1 active, 2 power-save, 3 deep power-down, 4 recovery |
| wsm_clear | output | 1 | Holds write machine and status in reset |
| op_busy | output | 1 | Operation running |
| result_invalid | output | 1 | Last operation was aborted by power-down |

## Verification
The hardest state to reach is the second arming gate. After a deep power-down that aborted an operation, the device must again be refused entry to power-save until `ce_n` moves. At the same time, the invalid flag must outlive the recovery window. The stimulus starts an operation and pulls `pd_n` low mid-operation. It counts the recovery cycles with a command write held active, leaves the device idle for several quiet periods with chip enable low, and only then completes a new operation to release the flag. Quiet-gap sweeps of every length shorter than the threshold show that the idle count restarts.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY = 3'd0,
    MD_ACTIVE  = 3'd1,
    MD_PSAVE   = 3'd2,
    MD_DPD     = 3'd3,
    MD_RECOVER = 3'd4
  } lps_mode_t;

  // saturating step of a quiet-time counter
  function automatic int unsigned sat_step(int unsigned cur, int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // last cycle of a window of len cycles counted from zero
  function automatic bit window_last(int unsigned cur, int unsigned len);
    return cur == len - 1;
  endfunction

endpackage

// File: rtl/lps_activity.sv
module lps_activity #(
  parameter int AW          = 4,
  parameter int IDLE_CYCLES = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_n,
  input  logic [AW-1:0] addr,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  output logic          act,
  output logic          idle_full,
  output logic          armed
);
  import lps_pkg::*;

  localparam int CW = $clog2(IDLE_CYCLES + 1);

  logic [AW-1:0] addr_q;
  logic          ce_q, oe_q, we_q;
  logic          primed;
  logic          ce_edge;
  logic [CW-1:0] idle_cnt;

  // first sampled cycle only loads the history; no edge is seen then
  assign ce_edge = primed && (ce_n != ce_q);
  assign act     = primed && ((addr != addr_q) || (ce_n != ce_q) ||
                              (oe_n != oe_q) || (we_n != we_q));
  assign idle_full = (int'(idle_cnt) == IDLE_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      we_q   <= 1'b1;
      primed <= 1'b0;
    end else begin
      addr_q <= addr;
      ce_q   <= ce_n;
      oe_q   <= oe_n;
      we_q   <= we_n;
      primed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               idle_cnt <= '0;
    else if (!primed || act)  idle_cnt <= '0;
    else                      idle_cnt <= CW'(sat_step(int'(idle_cnt), IDLE_CYCLES));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        armed <= 1'b0;
    else if (!pd_n)    armed <= 1'b0;
    else if (ce_edge)  armed <= 1'b1;
  end

  // R1: a sampled change always restarts the quiet count
  a_r1_restart: assert property (@(posedge clk) disable iff (!rst_n)
    act |=> (idle_cnt == '0));

  // R2: arming is lost on deep power-down
  a_r2_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !armed);

endmodule

// File: rtl/lps_recovery.sv
module lps_recovery #(
  parameter int RECOV_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic running,
  output logic done
);
  import lps_pkg::*;

  localparam int RW = (RECOV_CYCLES < 2) ? 1 : $clog2(RECOV_CYCLES);

  logic [RW-1:0] rcnt;

  assign done = running && window_last(int'(rcnt), RECOV_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rcnt <= '0;
    else if (start)            rcnt <= '0;
    else if (running && !done) rcnt <= rcnt + 1'b1;
  end

  // R9: the window counter never runs past its length
  a_r9_bound: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (int'(rcnt) < RECOV_CYCLES));

endmodule

// File: rtl/lps_datahold.sv
module lps_datahold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          holding,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] dq_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dq_out <= '0;
    else if (clr)   dq_out <= '0;
    else if (load)  dq_out <= rd_data;
  end

  // R3: held word does not move while power-save persists
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (holding && $past(holding)) |-> $stable(dq_out));

endmodule

// File: rtl/lps_supervisor.sv
module lps_supervisor #(
  parameter int AW           = 4,
  parameter int DW           = 8,
  parameter int IDLE_CYCLES  = 6,
  parameter int RECOV_CYCLES = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pd_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] rd_data,
  input  logic          op_start,
  input  logic          op_done,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic          cmd_accept,
  output logic [2:0]    mode,
  output logic          wsm_clear,
  output logic          op_busy,
  output logic          result_invalid
);
  import lps_pkg::*;

  lps_mode_t mode_q, mode_d, op_mode;
  logic act, idle_full, armed;
  logic rec_start, rec_run, rec_done;
  logic rd_cond, in_psave, in_off, latch_en;
  logic busy_q, inval_q;

  lps_activity #(.AW(AW), .IDLE_CYCLES(IDLE_CYCLES)) u_act (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .addr(addr),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .act(act), .idle_full(idle_full), .armed(armed)
  );

  assign rec_start = (mode_q == MD_DPD) && pd_n;
  assign rec_run   = (mode_q == MD_RECOVER);

  lps_recovery #(.RECOV_CYCLES(RECOV_CYCLES)) u_rec (
    .clk(clk), .rst_n(rst_n), .start(rec_start),
    .running(rec_run), .done(rec_done)
  );

  assign in_psave = (mode_q == MD_PSAVE);
  assign in_off   = (mode_q == MD_DPD) || (mode_q == MD_RECOVER);
  assign rd_cond  = !ce_n && !oe_n && we_n;

  // operating mode once power-down and recovery are out of the way
  always_comb begin
    if (ce_n)                            op_mode = busy_q ? MD_ACTIVE : MD_STANDBY;
    else if (in_psave && !act)           op_mode = MD_PSAVE;
    else if (armed && !busy_q && !act && idle_full) op_mode = MD_PSAVE;
    else                                 op_mode = MD_ACTIVE;
  end

  always_comb begin
    if (!pd_n) mode_d = MD_DPD;
    else begin
      case (mode_q)
        MD_DPD:     mode_d = MD_RECOVER;
        MD_RECOVER: mode_d = rec_done ? op_mode : MD_RECOVER;
        default:    mode_d = op_mode;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MD_STANDBY;
    else        mode_q <= mode_d;
  end

  assign latch_en = rd_cond && (mode_d == MD_ACTIVE);

  lps_datahold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .clr(!pd_n), .load(latch_en),
    .holding(in_psave), .rd_data(rd_data), .dq_out(dq_out)
  );

  assign dq_oe      = rd_cond && ((mode_q == MD_ACTIVE) || in_psave);
  assign cmd_accept = !ce_n && !we_n && !in_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       busy_q <= 1'b0;
    else if (!pd_n)                   busy_q <= 1'b0;
    else if (op_done)                 busy_q <= 1'b0;
    else if (op_start && cmd_accept)  busy_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  inval_q <= 1'b0;
    else if (!pd_n && busy_q)    inval_q <= 1'b1;
    else if (op_done && busy_q)  inval_q <= 1'b0;
  end

  assign mode           = mode_q;
  assign wsm_clear      = (mode_q == MD_DPD);
  assign op_busy        = busy_q;
  assign result_invalid = inval_q;

  // R1: power-save is only reached from a full quiet count
  a_r1_needs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_psave) |-> $past(idle_full));

  // R2: power-save requires arming
  a_r2_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    in_psave |-> armed);

  // R5: chip enable high means outputs off
  a_r5_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !dq_oe);

  // R6: a busy operation keeps the device out of standby
  a_r6_busy_active: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && pd_n) |=> (mode_q != MD_STANDBY));

  // R7: power-down request clears the write machine next cycle
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (wsm_clear && !busy_q));

  // R8: abort marks the result invalid
  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (!pd_n && busy_q) |=> inval_q);

  // R9: no command accepted while off or recovering
  a_r9_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    in_off |-> !cmd_accept);

endmodule

// File: tb/lps_supervisor_test.sv
module lps_supervisor_test;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int IDLE = 6;
  localparam int RECOV = 5;

  logic clk = 1'b0;
  logic rst_n, pd_n, ce_n, oe_n, we_n, op_start, op_done;
  logic [AW-1:0] addr;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] dq_out;
  logic dq_oe, cmd_accept, wsm_clear, op_busy, result_invalid;
  logic [2:0] mode;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  lps_supervisor #(.AW(AW), .DW(DW), .IDLE_CYCLES(IDLE), .RECOV_CYCLES(RECOV)) uut (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .rd_data(rd_data), .op_start(op_start), .op_done(op_done),
    .dq_out(dq_out), .dq_oe(dq_oe), .cmd_accept(cmd_accept), .mode(mode),
    .wsm_clear(wsm_clear), .op_busy(op_busy), .result_invalid(result_invalid)
  );

  function automatic logic [DW-1:0] word_at(int a);
    return DW'((a * 37 + 5) & 8'hFF);
  endfunction

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // steps until power-save shows, returns count (limit 40)
  task automatic steps_to_psave(output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (mode != 3'd2 && n < 40);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    int a;
    rst_n = 0; pd_n = 1; ce_n = 0; oe_n = 1; we_n = 1;
    addr = 0; rd_data = word_at(0); op_start = 0; op_done = 0;
    #5;
    chk(mode == 3'd0, "R5 reset mode", mode, 0);
    chk(dq_oe == 1'b0 && cmd_accept == 1'b0, "R10 reset outputs", {dq_oe, cmd_accept}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2: never armed, chip enable low all along
    repeat (3 * IDLE) step();
    chk(mode == 3'd1, "R2 unarmed stays active", mode, 1);

    // R5: standby and high impedance
    ce_n = 1; oe_n = 0;
    step();
    chk(mode == 3'd0, "R5 standby", mode, 0);
    chk(dq_oe == 1'b0, "R5 high-Z", dq_oe, 0);

    // R1: change sampled at first edge, psave IDLE+1 edges later
    ce_n = 0;
    steps_to_psave(n);
    chk(n == IDLE + 2, "R1 quiet count", n, IDLE + 2);
    chk(dq_oe == 1'b1 && dq_out == word_at(0), "R3 psave drives held", dq_out, word_at(0));

    // R3: array data changes, output holds
    rd_data = ~word_at(0);
    repeat (3) step();
    chk(mode == 3'd2, "R3 stays psave", mode, 2);
    chk(dq_out == word_at(0), "R3 hold", dq_out, word_at(0));
    addr = 5; rd_data = word_at(5);
    step();
    chk(mode == 3'd1, "R3 exit on address", mode, 1);
    chk(dq_out == word_at(5), "R3 new read", dq_out, word_at(5));

    // R1: every gap shorter than the threshold restarts the count
    for (int g = 1; g <= IDLE + 1; g++) begin
      bit seen;
      seen = 0;
      for (int s = 0; s < g; s++) begin
        step();
        if (mode == 3'd2) seen = 1;
      end
      chk(!seen, "R1 short gap", g, 0);
      addr = AW'(addr + 1); rd_data = word_at(int'(addr));
    end
    steps_to_psave(n);
    chk(n == IDLE + 2, "R1 after gaps", n, IDLE + 2);

    // R4: read sweep over all addresses
    oe_n = 1;
    step();
    chk(dq_oe == 1'b0, "R4 oe high", dq_oe, 0);
    oe_n = 0;
    for (a = 0; a < (1 << AW); a++) begin
      addr = AW'(a); rd_data = word_at(a);
      step();
      chk(dq_out == word_at(a) && dq_oe == 1'b1, "R4 read word", dq_out, word_at(a));
    end

    // R10/R6: accepted command, busy keeps active with chip enable high
    oe_n = 1; we_n = 0; op_start = 1;
    #1;
    chk(cmd_accept == 1'b1, "R10 accept", cmd_accept, 1);
    step();
    op_start = 0; we_n = 1; ce_n = 1;
    chk(op_busy == 1'b1, "R10 busy set", op_busy, 1);
    repeat (2) step();
    chk(mode == 3'd1, "R6 busy active", mode, 1);
    chk(dq_oe == 1'b0, "R5 high-Z while busy", dq_oe, 0);
    op_done = 1;
    step();
    op_done = 0;
    step();
    chk(mode == 3'd0, "R6 standby after done", mode, 0);

    // R7/R8: abort with power-down
    ce_n = 0; we_n = 0; op_start = 1;
    step();
    op_start = 0; we_n = 1;
    step();
    pd_n = 0;
    step();
    chk(mode == 3'd3, "R7 dpd mode", mode, 3);
    chk(wsm_clear == 1'b1 && op_busy == 1'b0, "R7 clear", {wsm_clear, op_busy}, 2);
    chk(result_invalid == 1'b1, "R8 invalid", result_invalid, 1);
    we_n = 0;
    #1;
    chk(cmd_accept == 1'b0, "R9 no accept in dpd", cmd_accept, 0);

    // R9: recovery length with a command write held
    pd_n = 1;
    n = 0;
    step();
    while (mode == 3'd4 && n < 40) begin
      n++;
      if (cmd_accept) chk(0, "R9 accept in recovery", 1, 0);
      step();
    end
    chk(n == RECOV, "R9 recovery length", n, RECOV);
    chk(mode == 3'd1 && cmd_accept == 1'b1, "R9 accept after", cmd_accept, 1);
    chk(result_invalid == 1'b1, "R8 invalid survives", result_invalid, 1);

    // R7: arming cancelled by power-down
    we_n = 1;
    repeat (3 * IDLE) step();
    chk(mode == 3'd1, "R7 disarmed", mode, 1);

    // R8: a new operation clears the flag on completion
    we_n = 0; op_start = 1;
    step();
    op_start = 0; we_n = 1;
    op_done = 1;
    step();
    op_done = 0;
    chk(result_invalid == 1'b0, "R8 cleared", result_invalid, 0);

    finish_run();
  end

endmodule